// File: doc/BRIEF.md
# Three-Wire Serial Register Access Slave

This block is the slave end of a three-wire serial link. The link has an active-high enable line, a serial clock and one bidirectional data pin. The master raises the enable line and clocks in a command byte. The command byte names a direction, a register and whether a single byte or a burst follows. The master then shifts data bytes in, or the block shifts them out. Command and data are both sent least significant bit first.

Toward the timekeeping logic the block presents a plain parallel port: a one-cycle write strobe with an address and a data byte, and a read address with a combinational read-data return. Register 7 holds the write-protect flag and lives inside this block. Writes to it are never forwarded, and while the flag is set every write to registers 0 to 6 is dropped. The serial clock, the enable line and the data input are synchronised into the system clock domain. That domain is assumed to run at least four times as fast as the serial clock.

Top module: `serial_regport`

## Requirements
- R1: During and after reset, the data-pin output enable is low and no write strobe is issued.
- R2: A single write command (1000aaa0, with aaa the register address in bits 3..1) followed by eight data bits issues exactly one write strobe carrying address aaa and the received byte. The strobe comes after the eighth data bit and only for registers 0 to 6.
- R3: A single read command (1000aaa1) returns the selected register on the data pin, least significant bit first. Each bit is updated on a serial-clock falling edge, starting with the falling edge after the eighth command bit. The output enable is high while the bits are driven.
- R4: Burst write (0xBE) takes eight bytes. It writes registers 0 to 6 in ascending order and then the write-protect register.
- R5: Burst read (0xBF) streams registers 0 to 6 in ascending order and then the write-protect register.
- R6: Test-mode commands (1001xxx1) change no register and never raise the output enable.
- R7: While the write-protect flag (bit 7 of register 7) is 1, writes to registers 0 to 6, whether single or burst, issue no strobe. Register 7 stays writable, and clearing the flag enables writes again.
- R8: Register 7 reads as the flag in bit 7 with bits 6..0 always zero. Writes to it are not forwarded on the write port.
- R9: Dropping the enable line abandons the transfer. The output enable falls within four system cycles, and a partly received byte is discarded.
- R10: Serial clocks after the last byte of a transfer are ignored until the enable line is dropped: one byte for single mode, eight for burst.
- R11: A command whose bit 7 is 0, or that matches no defined code, is ignored.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Synchronous active-low reset |
| ce_i | input | 1 | Serial enable line, active high |
| sclk_i | input | 1 | Serial clock from the master |
| sdio_i | input | 1 | Data pin input value |
| sdio_o | output | 1 | Data pin output value |
| sdio_oe | output | 1 | Data pin output enable |
| rf_wr_en | output | 1 | One-cycle write strobe to the register file |
| rf_waddr | output | 3 | Write address |
| rf_wdata | output | 8 | Write data |
| rf_raddr | output | 3 | Read address |
| rf_rdata | input | 8 | Combinational read data for rf_raddr |

## Verification
A pin edge reaches the logic three system cycles after it happens: two cycles in the synchroniser and one for edge detection. A write strobe therefore appears on the fourth cycle after the eighth data rising edge. A read bit lands on sdio_o on the fourth cycle after a falling edge. The output enable drops on the fourth cycle after the enable line falls. The bench holds each serial-clock phase for six system cycles and samples sdio_o on the last falling system edge of the low phase. After every transfer it leaves twelve idle cycles before it compares write counts or the output enable, so each result is read only once it has settled.

// File: rtl/srp_pkg.sv
// Shared constants and types for the three-wire register slave.
// Assumes a fixed 8-bit byte and eight addressable registers.
package srp_pkg;
    localparam int DATA_W    = 8;
    localparam int NUM_REGS  = 8;
    localparam int ADDR_W    = $clog2(NUM_REGS);
    localparam logic [ADDR_W-1:0] WP_ADDR   = ADDR_W'(NUM_REGS - 1);
    localparam logic [ADDR_W-1:0] LAST_BYTE = ADDR_W'(NUM_REGS - 1);
    localparam int BIT_W     = $clog2(DATA_W);

    typedef enum logic [1:0] {
        ST_CMD,
        ST_WR,
        ST_RD,
        ST_DONE
    } srp_state_t;
endpackage

// File: rtl/srp_sync.sv
// Multi-bit level synchroniser: each input bit passes through STAGES flops.
// Assumes the bits are independent slow levels; no bus coherence implied.
module srp_sync #(
    parameter int STAGES = 2,
    parameter int WIDTH  = 1
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic [WIDTH-1:0] d,
    output logic [WIDTH-1:0] q
);
    logic [WIDTH-1:0] chain [STAGES];

    for (genvar s = 0; s < STAGES; s++) begin : g_stage
        // Purpose: one flop rank of the synchroniser chain.
        always_ff @(posedge clk) begin
            if (!rst_n)      chain[s] <= '0;
            else if (s == 0) chain[s] <= d;
            else             chain[s] <= chain[(s == 0) ? 0 : s - 1];
        end
    end

    assign q = chain[STAGES-1];
endmodule

// File: rtl/srp_cmd_decode.sv
// Command byte decoder. Recognises single access 1000aaar and burst
// 1011111r; every other code (test mode included) is reported invalid.
module srp_cmd_decode
    import srp_pkg::*;
(
    input  logic [DATA_W-1:0] cmd_i,
    output logic              valid_o,
    output logic              read_o,
    output logic              burst_o,
    output logic [ADDR_W-1:0] addr_o
);
    logic single;

    // Purpose: classify the command and extract the start address.
    always_comb begin
        single  = (cmd_i[7:4] == 4'b1000);
        burst_o = (cmd_i[7:1] == 7'b1011111);
        valid_o = single | burst_o;
        read_o  = cmd_i[0];
        addr_o  = burst_o ? '0 : cmd_i[3:1];
    end
endmodule

// File: rtl/serial_regport.sv
// Three-wire serial slave with a parallel register-file port.
// Assumes the system clock is at least 4x the serial clock, data is stable
// around the serial rising edge, and sclk is low when ce_i rises.
// Register 7 (write-protect flag) is held here; 0..6 live outside.
module serial_regport
    import srp_pkg::*;
#(
    parameter int SYNC_STAGES = 2
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              ce_i,
    input  logic              sclk_i,
    input  logic              sdio_i,
    output logic              sdio_o,
    output logic              sdio_oe,
    output logic              rf_wr_en,
    output logic [ADDR_W-1:0] rf_waddr,
    output logic [DATA_W-1:0] rf_wdata,
    output logic [ADDR_W-1:0] rf_raddr,
    input  logic [DATA_W-1:0] rf_rdata
);
    logic [2:0]        sync_q;
    logic              ce_s, sclk_s, din_s, sclk_d;
    logic              rise, fall;
    srp_state_t        state;
    logic [BIT_W-1:0]  bit_cnt;
    logic [ADDR_W-1:0] byte_cnt;
    logic [ADDR_W-1:0] addr_q;
    logic [DATA_W-1:0] sh, obyte, byte_in, rd_value;
    logic              burst_q, wp_q, last_byte;
    logic              dec_valid, dec_read, dec_burst;
    logic [ADDR_W-1:0] dec_addr;

    srp_sync #(.STAGES(SYNC_STAGES), .WIDTH(3)) u_sync (
        .clk   (clk),
        .rst_n (rst_n),
        .d     ({ce_i, sclk_i, sdio_i}),
        .q     (sync_q)
    );

    assign ce_s   = sync_q[2];
    assign sclk_s = sync_q[1];
    assign din_s  = sync_q[0];

    srp_cmd_decode u_dec (
        .cmd_i   (byte_in),
        .valid_o (dec_valid),
        .read_o  (dec_read),
        .burst_o (dec_burst),
        .addr_o  (dec_addr)
    );

    // Purpose: delayed serial clock for edge detection.
    always_ff @(posedge clk) begin
        if (!rst_n) sclk_d <= 1'b0;
        else        sclk_d <= sclk_s;
    end

    // Purpose: edge strobes, qualified by the synchronised enable.
    always_comb begin
        rise      = ce_s & sclk_s & ~sclk_d;
        fall      = ce_s & ~sclk_s & sclk_d;
        byte_in   = {din_s, sh[DATA_W-1:1]};
        rd_value  = (addr_q == WP_ADDR) ? {wp_q, {(DATA_W-1){1'b0}}} : rf_rdata;
        last_byte = !burst_q || (byte_cnt == LAST_BYTE);
    end

    assign rf_raddr = addr_q;

    // Purpose: transfer sequencer, shifter, write-protect flag and pin drive.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            state    <= ST_CMD;
            bit_cnt  <= '0;
            byte_cnt <= '0;
            addr_q   <= '0;
            sh       <= '0;
            obyte    <= '0;
            burst_q  <= 1'b0;
            wp_q     <= 1'b0;
            sdio_o   <= 1'b0;
            sdio_oe  <= 1'b0;
            rf_wr_en <= 1'b0;
            rf_waddr <= '0;
            rf_wdata <= '0;
        end else begin
            rf_wr_en <= 1'b0;
            if (!ce_s) begin
                state    <= ST_CMD;
                bit_cnt  <= '0;
                byte_cnt <= '0;
                burst_q  <= 1'b0;
                sdio_oe  <= 1'b0;
            end else begin
                case (state)
                    ST_CMD: if (rise) begin
                        sh      <= byte_in;
                        bit_cnt <= bit_cnt + 1'b1;
                        if (bit_cnt == BIT_W'(DATA_W - 1)) begin
                            if (!dec_valid) begin
                                state <= ST_DONE;
                            end else begin
                                addr_q  <= dec_addr;
                                burst_q <= dec_burst;
                                state   <= dec_read ? ST_RD : ST_WR;
                            end
                        end
                    end
                    ST_WR: if (rise) begin
                        sh      <= byte_in;
                        bit_cnt <= bit_cnt + 1'b1;
                        if (bit_cnt == BIT_W'(DATA_W - 1)) begin
                            if (addr_q == WP_ADDR) begin
                                wp_q <= din_s;
                            end else if (!wp_q) begin
                                rf_wr_en <= 1'b1;
                                rf_waddr <= addr_q;
                                rf_wdata <= byte_in;
                            end
                            if (last_byte) begin
                                state <= ST_DONE;
                            end else begin
                                byte_cnt <= byte_cnt + 1'b1;
                                addr_q   <= addr_q + 1'b1;
                            end
                        end
                    end
                    ST_RD: begin
                        if (fall) begin
                            sdio_oe <= 1'b1;
                            if (bit_cnt == '0) begin
                                obyte  <= rd_value;
                                sdio_o <= rd_value[0];
                            end else begin
                                sdio_o <= obyte[bit_cnt];
                            end
                        end
                        if (rise) begin
                            bit_cnt <= bit_cnt + 1'b1;
                            if (bit_cnt == BIT_W'(DATA_W - 1)) begin
                                if (last_byte) begin
                                    state   <= ST_DONE;
                                    sdio_oe <= 1'b0;
                                end else begin
                                    byte_cnt <= byte_cnt + 1'b1;
                                    addr_q   <= addr_q + 1'b1;
                                end
                            end
                        end
                    end
                    default: ;
                endcase
            end
        end
    end
endmodule

// File: rtl/srp_checker.sv
// Property checker for serial_regport, attached by bind below.
// Observes the synchronised enable, pin enable, write port and flag.
module srp_checker
    import srp_pkg::*;
(
    input logic              clk,
    input logic              rst_n,
    input logic              ce_s,
    input logic              sdio_oe,
    input logic              rf_wr_en,
    input logic [ADDR_W-1:0] rf_waddr,
    input logic              wp_q
);
    // R9
    ce_drop_release_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !ce_s |=> !sdio_oe);

    // R3
    oe_needs_ce_chk: assert property (@(posedge clk) disable iff (!rst_n)
        sdio_oe |-> $past(ce_s));

    // R7
    wp_blocks_write_chk: assert property (@(posedge clk) disable iff (!rst_n)
        rf_wr_en |-> !wp_q);

    // R8
    no_wp_forward_chk: assert property (@(posedge clk) disable iff (!rst_n)
        rf_wr_en |-> (rf_waddr != WP_ADDR));

    // R2
    single_strobe_chk: assert property (@(posedge clk) disable iff (!rst_n)
        rf_wr_en |=> !rf_wr_en);

    // R1
    reset_quiet_chk: assert property (@(posedge clk)
        !rst_n |=> (!sdio_oe && !rf_wr_en));
endmodule

bind serial_regport srp_checker u_srp_chk (
    .clk      (clk),
    .rst_n    (rst_n),
    .ce_s     (ce_s),
    .sdio_oe  (sdio_oe),
    .rf_wr_en (rf_wr_en),
    .rf_waddr (rf_waddr),
    .wp_q     (wp_q)
);

// File: tb/test_serial_regport.sv
// Self-checking bench: a vector table of single write/read pairs, then
// directed tests for burst, protection, test mode, abort and overrun.
module test_serial_regport;
    localparam int H = 6;
    localparam logic [10:0] VEC [0:6] = '{
        {3'd0, 8'h45}, {3'd1, 8'h59}, {3'd2, 8'h12}, {3'd3, 8'h31},
        {3'd4, 8'h09}, {3'd5, 8'h07}, {3'd6, 8'h99}
    };

    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic       ce = 1'b0, sclk = 1'b0, sdi = 1'b0;
    logic       sdo, oe, wr_en;
    logic [2:0] waddr, raddr;
    logic [7:0] wdata, rdata;
    logic [7:0] mem [0:7];
    logic [7:0] expv [0:7];
    int         wr_count = 0;
    int         n_checks = 0, n_fail = 0;
    bit         finished = 1'b0;

    always #5 clk = ~clk;

    serial_regport i_serial_regport (
        .clk (clk), .rst_n (rst_n), .ce_i (ce), .sclk_i (sclk), .sdio_i (sdi),
        .sdio_o (sdo), .sdio_oe (oe), .rf_wr_en (wr_en), .rf_waddr (waddr),
        .rf_wdata (wdata), .rf_raddr (raddr), .rf_rdata (rdata)
    );

    // Register file model and write counter.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            for (int k = 0; k < 8; k++) mem[k] <= 8'h00;
        end else if (wr_en) begin
            mem[waddr] <= wdata;
            wr_count   <= wr_count + 1;
        end
    end
    assign rdata = mem[raddr];

    task automatic chk(input bit ok, input string tag, input logic [31:0] act, input logic [31:0] exp);
        n_checks++;
        if (!ok) begin
            n_fail++;
            $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
        end
    endtask

    task automatic xfer(input logic [7:0] cmd, input int nbits, input logic [71:0] wbits,
                        output logic [71:0] rbits, output bit oe_seen);
        rbits = '0; oe_seen = 1'b0;
        @(negedge clk); ce = 1'b1;
        repeat (H) @(negedge clk);
        for (int i = 0; i < 8; i++) begin
            sclk = 1'b0; sdi = cmd[i];
            repeat (H) @(negedge clk);
            sclk = 1'b1;
            repeat (H) @(negedge clk);
        end
        for (int i = 0; i < nbits; i++) begin
            sclk = 1'b0; sdi = wbits[i];
            repeat (H) @(negedge clk);
            rbits[i] = sdo;
            if (oe) oe_seen = 1'b1;
            sclk = 1'b1;
            repeat (H) @(negedge clk);
        end
        sclk = 1'b0;
        repeat (H) @(negedge clk);
        ce = 1'b0; sdi = 1'b0;
        repeat (12) @(negedge clk);
    endtask

    task automatic wr1(input logic [2:0] a, input logic [7:0] d);
        logic [71:0] rb; bit o;
        xfer({4'b1000, a, 1'b0}, 8, {64'h0, d}, rb, o);
    endtask

    task automatic rd1(input logic [2:0] a, output logic [7:0] d, output bit o);
        logic [71:0] rb;
        xfer({4'b1000, a, 1'b1}, 8, 72'h0, rb, o);
        d = rb[7:0];
    endtask

    initial begin : watchdog
        repeat (200000) @(posedge clk);
        if (!finished) begin
            n_checks++; n_fail++;
            $display("FAIL watchdog actual=timeout expected=done");
            $display("End of test - %0d assertions evaluated, %0d failures", n_checks, n_fail);
            $finish;
        end
    end

    initial begin : main
        logic [71:0] rb;
        logic [7:0]  r;
        bit          o;
        int          c0;
        for (int k = 0; k < 8; k++) expv[k] = 8'h00;

        // R1: quiet during and after reset
        repeat (5) @(negedge clk);
        chk(!oe && !wr_en, "R1 in reset", {oe, wr_en}, 0);
        rst_n = 1'b1;
        repeat (5) @(negedge clk);
        chk(!oe && !wr_en, "R1 after reset", {oe, wr_en}, 0);

        // R2/R3: vector table of single writes and reads
        for (int i = 0; i < 7; i++) begin
            c0 = wr_count;
            wr1(VEC[i][10:8], VEC[i][7:0]);
            chk(wr_count == c0 + 1, "R2 one strobe", wr_count - c0, 1);
            chk(mem[VEC[i][10:8]] == VEC[i][7:0], "R2 stored byte", mem[VEC[i][10:8]], VEC[i][7:0]);
            expv[VEC[i][10:8]] = VEC[i][7:0];
            rd1(VEC[i][10:8], r, o);
            chk(r == VEC[i][7:0], "R3 read data", r, VEC[i][7:0]);
            chk(o, "R3 oe driven", o, 1);
        end

        // R4: burst write 0..6 then register 7 (flag left clear)
        c0 = wr_count;
        xfer(8'hBE, 64, {8'h00, 8'h66, 8'h55, 8'h44, 8'h33, 8'h22, 8'h11, 8'h10, 8'h00} >> 8, rb, o);
        chk(wr_count == c0 + 7, "R4 strobes", wr_count - c0, 7);
        for (int k = 0; k < 7; k++) expv[k] = 8'h10 + 8'(k * 8'h11) - 8'(k == 0 ? 0 : 0);
        expv[0] = 8'h10; expv[1] = 8'h11; expv[2] = 8'h22; expv[3] = 8'h33;
        expv[4] = 8'h44; expv[5] = 8'h55; expv[6] = 8'h66;
        chk(mem[0] == 8'h10 && mem[6] == 8'h66, "R4 order", {mem[0], mem[6]}, 16'h1066);

        // R5: burst read in ascending order, register 7 last
        xfer(8'hBF, 64, 72'h0, rb, o);
        for (int k = 0; k < 8; k++)
            chk(rb[8*k +: 8] == expv[k], "R5 burst byte", rb[8*k +: 8], expv[k]);

        // R8: low bits of register 7 read zero, writes not forwarded
        c0 = wr_count;
        wr1(3'd7, 8'h7F);
        chk(wr_count == c0, "R8 no forward", wr_count - c0, 0);
        rd1(3'd7, r, o);
        chk(r == 8'h00, "R8 low bits zero", r, 8'h00);
        wr1(3'd7, 8'h80);
        rd1(3'd7, r, o);
        chk(r == 8'h80, "R8 flag reads back", r, 8'h80);

        // R7: protection blocks single and burst writes
        c0 = wr_count;
        wr1(3'd2, 8'hA5);
        chk(wr_count == c0, "R7 single blocked", wr_count - c0, 0);
        rd1(3'd2, r, o);
        chk(r == expv[2], "R7 data kept", r, expv[2]);
        xfer(8'hBE, 64, {8'h80, 8'hAA, 8'hAA, 8'hAA, 8'hAA, 8'hAA, 8'hAA, 8'hAA}, rb, o);
        chk(wr_count == c0, "R7 burst blocked", wr_count - c0, 0);
        wr1(3'd7, 8'h00);
        wr1(3'd2, 8'hA5);
        chk(wr_count == c0 + 1, "R7 unprotected", wr_count - c0, 1);
        expv[2] = 8'hA5;
        rd1(3'd2, r, o);
        chk(r == 8'hA5, "R7 write after clear", r, 8'hA5);

        // R6: test-mode commands do nothing
        c0 = wr_count;
        xfer(8'h93, 8, {64'h0, 8'h3C}, rb, o);
        chk(wr_count == c0 && !o, "R6 test 0x93", {wr_count - c0, 31'(o)}, 0);
        xfer(8'h9F, 16, 72'hFFFF, rb, o);
        chk(wr_count == c0 && !o, "R6 test 0x9F", {wr_count - c0, 31'(o)}, 0);

        // R11: undefined command ignored
        xfer(8'h04, 8, {64'h0, 8'h11}, rb, o);
        chk(wr_count == c0 && !o, "R11 undefined", wr_count - c0, 0);
        rd1(3'd2, r, o);
        chk(r == 8'hA5, "R11 data kept", r, 8'hA5);

        // R9: abort mid-byte drops it and releases the pin
        c0 = wr_count;
        xfer(8'h82, 4, 72'hF, rb, o);
        chk(wr_count == c0, "R9 partial dropped", wr_count - c0, 0);
        rd1(3'd1, r, o);
        chk(r == expv[1], "R9 data kept", r, expv[1]);
        xfer(8'h83, 3, 72'h0, rb, o);
        chk(o, "R9 oe was on", o, 1);
        chk(!oe, "R9 oe released", oe, 0);

        // R10: clocks after the last byte are ignored
        c0 = wr_count;
        xfer(8'h86, 16, {56'h0, 8'hBB, 8'h27}, rb, o);
        chk(wr_count == c0 + 1, "R10 single overrun", wr_count - c0, 1);
        rd1(3'd3, r, o);
        chk(r == 8'h27, "R10 first byte kept", r, 8'h27);
        c0 = wr_count;
        xfer(8'hBE, 72, {8'hF0, 8'h00, 8'h17, 8'h16, 8'h15, 8'h14, 8'h13, 8'h12, 8'h11}, rb, o);
        chk(wr_count == c0 + 7, "R10 burst overrun", wr_count - c0, 7);
        rd1(3'd0, r, o);
        chk(r == 8'h11, "R10 reg0 not overwritten", r, 8'h11);
        rd1(3'd7, r, o);
        chk(r == 8'h00, "R10 flag clear", r, 8'h00);

        finished = 1'b1;
        $display("End of test - %0d assertions evaluated, %0d failures", n_checks, n_fail);
        $finish;
    end
endmodule